// File: doc/BRIEF.md
# Dual-Issue In-Order Scoreboard Issue Unit

This block sits between a decoded-instruction queue and two execution pipes. Each cycle the queue may present two instructions: the older one on slot 0 and the younger one on slot 1. Each instruction may name two source registers and one destination register. Each register field has its own enable. Each instruction also carries a fixed result latency and a flag that marks use of the single shared multiplier. The unit decides which of the two instructions leave for the pipes this cycle. Slot 0 always goes to pipe 0 and slot 1 always goes to pipe 1.

A scoreboard holds a down-counter for every architectural register. The counter gives the number of cycles before a consumer may read the pending result. A writer with latency L that issues in cycle t lets a dependent issue in cycle t+L at the earliest. Latency 0 is treated as 1. All results are written back at a fixed point at the end of the pipes, so a write-after-read hazard cannot occur and is not checked. A flush input empties the scoreboard and blocks all issue in that cycle.

The queue side uses valid/ready. `inK_ready` is high exactly when slot K issues in that cycle. An instruction is consumed when its valid and ready are both high; otherwise the queue must hold it unchanged. Ready is derived combinationally from valid and from the scoreboard. The queue must therefore not make valid depend on ready. Slot 1 must only be valid when slot 0 is valid. `stall` is a plain status pin.

Top module: `dis_issue_unit`

## Requirements
- R1: `pipeK_valid` equals `inK_ready`, and both can be high only while `inK_valid` is high; slot 0 feeds pipe 0 and slot 1 feeds pipe 1.
- R2: Slot 1 never issues in a cycle where slot 0 does not issue.
- R3: An enabled source whose register has a nonzero pending count blocks its instruction. After a writer of latency L (0 counted as 1) issues in cycle t, a reader of that register issues in cycle t+L if nothing else blocks it, and not earlier.
- R4: When slot 1 reads a register that slot 0 writes in the same cycle, slot 1 does not issue. It can issue in a later cycle, presented as slot 0.
- R5: When both slots set the multiplier flag, only slot 0 may issue.
- R6: A writer stalls while the pending count of its destination exceeds its own L-1. Within a pair that writes the same destination, slot 1 is held if its L-1 is smaller than that of slot 0. The count a writer leaves is the larger of the decremented count and its own L-1.
- R7: `stall` is high exactly when a valid slot does not issue.
- R8: While `flush` is high, neither slot issues. From the next cycle on, every register counts as available.
- R9: After reset every register is available, so an instruction with any sources issues at once.
- R10: A register field whose enable is low is ignored for all hazard checks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| flush | input | 1 | Clear scoreboard and block issue this cycle |
| in0_valid | input | 1 | Slot 0 (older) instruction present |
| in0_ready | output | 1 | Slot 0 issues this cycle |
| in0_src_a | input | REGW | Slot 0 first source register |
| in0_src_a_en | input | 1 | Slot 0 first source used |
| in0_src_b | input | REGW | Slot 0 second source register |
| in0_src_b_en | input | 1 | Slot 0 second source used |
| in0_dst | input | REGW | Slot 0 destination register |
| in0_dst_en | input | 1 | Slot 0 writes a register |
| in0_lat | input | LATW | Slot 0 result latency |
| in0_mul | input | 1 | Slot 0 needs the shared multiplier |
| in1_valid | input | 1 | Slot 1 (younger) instruction present |
| in1_ready | output | 1 | Slot 1 issues this cycle |
| in1_src_a | input | REGW | Slot 1 first source register |
| in1_src_a_en | input | 1 | Slot 1 first source used |
| in1_src_b | input | REGW | Slot 1 second source register |
| in1_src_b_en | input | 1 | Slot 1 second source used |
| in1_dst | input | REGW | Slot 1 destination register |
| in1_dst_en | input | 1 | Slot 1 writes a register |
| in1_lat | input | LATW | Slot 1 result latency |
| in1_mul | input | 1 | Slot 1 needs the shared multiplier |
| pipe0_valid | output | 1 | Instruction enters pipe 0 |
| pipe1_valid | output | 1 | Instruction enters pipe 1 |
| stall | output | 1 | A valid slot was held back |

## Verification
The only state is the counter array, and it shows at the ports only through the ready outputs. A wrong count therefore appears as a reader that issues too early or stalls too long. It becomes visible in the first cycle a later instruction names that register. The bench presents readers of pending registers in every cycle, so a counter that is off by one is seen at the exact cycle boundary L after its writer. A counter that survives a flush is seen in the cycle right after the flush.

// File: rtl/dis_pkg.sv
package dis_pkg;
  localparam int NSLOT = 2;

  typedef enum logic [2:0] {
    HZ_NONE,
    HZ_RAW,
    HZ_WAW,
    HZ_PAIR_RAW,
    HZ_PAIR_WAW,
    HZ_RESOURCE,
    HZ_ORDER,
    HZ_FLUSH
  } hz_e;
endpackage

// File: rtl/dis_scoreboard.sv
module dis_scoreboard #(
  parameter int NREG = 16,
  parameter int LATW = 4,
  localparam int REGW = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            flush,
  input  logic            wr_en  [dis_pkg::NSLOT],
  input  logic [REGW-1:0] wr_idx [dis_pkg::NSLOT],
  input  logic [LATW-1:0] wr_load[dis_pkg::NSLOT],
  output logic [LATW-1:0] cnt    [NREG]
);
  logic [LATW-1:0] cnt_q [NREG];
  logic [LATW-1:0] cnt_d [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_comb begin
      cnt_d[g] = (cnt_q[g] == '0) ? '0 : cnt_q[g] - LATW'(1);
      for (int k = 0; k < dis_pkg::NSLOT; k++) begin
        if (wr_en[k] && (wr_idx[k] == REGW'(g)) && (wr_load[k] > cnt_d[g])) begin
          cnt_d[g] = wr_load[k];
        end
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt_q[g] <= '0;
      end else if (flush) begin
        cnt_q[g] <= '0;
      end else begin
        cnt_q[g] <= cnt_d[g];
      end
    end

    assign cnt[g] = cnt_q[g];
  end
endmodule

// File: rtl/dis_slot_hazard.sv
module dis_slot_hazard #(
  parameter int NREG = 16,
  parameter int LATW = 4,
  localparam int REGW = $clog2(NREG)
) (
  input  logic [LATW-1:0] cnt [NREG],
  input  logic [REGW-1:0] src_a,
  input  logic            src_a_en,
  input  logic [REGW-1:0] src_b,
  input  logic            src_b_en,
  input  logic [REGW-1:0] dst,
  input  logic            dst_en,
  input  logic [LATW-1:0] lat,
  output logic [LATW-1:0] load,
  output dis_pkg::hz_e    hz
);
  logic raw_a, raw_b, waw;

  assign load  = (lat == '0) ? '0 : lat - LATW'(1);
  assign raw_a = src_a_en && (cnt[src_a] != '0);
  assign raw_b = src_b_en && (cnt[src_b] != '0);
  assign waw   = dst_en && (cnt[dst] > load);

  always_comb begin
    if (raw_a || raw_b) hz = dis_pkg::HZ_RAW;
    else if (waw)       hz = dis_pkg::HZ_WAW;
    else                hz = dis_pkg::HZ_NONE;
  end
endmodule

// File: rtl/dis_issue_unit.sv
module dis_issue_unit #(
  parameter int NREG = 16,
  parameter int LATW = 4,
  localparam int REGW = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            flush,
  input  logic            in0_valid,
  output logic            in0_ready,
  input  logic [REGW-1:0] in0_src_a,
  input  logic            in0_src_a_en,
  input  logic [REGW-1:0] in0_src_b,
  input  logic            in0_src_b_en,
  input  logic [REGW-1:0] in0_dst,
  input  logic            in0_dst_en,
  input  logic [LATW-1:0] in0_lat,
  input  logic            in0_mul,
  input  logic            in1_valid,
  output logic            in1_ready,
  input  logic [REGW-1:0] in1_src_a,
  input  logic            in1_src_a_en,
  input  logic [REGW-1:0] in1_src_b,
  input  logic            in1_src_b_en,
  input  logic [REGW-1:0] in1_dst,
  input  logic            in1_dst_en,
  input  logic [LATW-1:0] in1_lat,
  input  logic            in1_mul,
  output logic            pipe0_valid,
  output logic            pipe1_valid,
  output logic            stall
);
  import dis_pkg::*;

  logic [REGW-1:0] s_src_a [NSLOT];
  logic            s_src_a_en [NSLOT];
  logic [REGW-1:0] s_src_b [NSLOT];
  logic            s_src_b_en [NSLOT];
  logic [REGW-1:0] s_dst [NSLOT];
  logic            s_dst_en [NSLOT];
  logic [LATW-1:0] s_lat [NSLOT];
  logic [LATW-1:0] s_load [NSLOT];
  hz_e             s_hz [NSLOT];
  hz_e             hz0, hz1;
  logic            iss [NSLOT];
  logic            wr_en [NSLOT];
  logic [LATW-1:0] cnt [NREG];

  assign s_src_a[0] = in0_src_a;  assign s_src_a[1] = in1_src_a;
  assign s_src_a_en[0] = in0_src_a_en;  assign s_src_a_en[1] = in1_src_a_en;
  assign s_src_b[0] = in0_src_b;  assign s_src_b[1] = in1_src_b;
  assign s_src_b_en[0] = in0_src_b_en;  assign s_src_b_en[1] = in1_src_b_en;
  assign s_dst[0] = in0_dst;  assign s_dst[1] = in1_dst;
  assign s_dst_en[0] = in0_dst_en;  assign s_dst_en[1] = in1_dst_en;
  assign s_lat[0] = in0_lat;  assign s_lat[1] = in1_lat;

  for (genvar k = 0; k < NSLOT; k++) begin : g_slot
    dis_slot_hazard #(.NREG(NREG), .LATW(LATW)) hz_i (
      .cnt      (cnt),
      .src_a    (s_src_a[k]),
      .src_a_en (s_src_a_en[k]),
      .src_b    (s_src_b[k]),
      .src_b_en (s_src_b_en[k]),
      .dst      (s_dst[k]),
      .dst_en   (s_dst_en[k]),
      .lat      (s_lat[k]),
      .load     (s_load[k]),
      .hz       (s_hz[k])
    );
    assign wr_en[k] = iss[k] && s_dst_en[k];
  end

  logic pair_raw, pair_waw, mul_clash;

  assign pair_raw = in0_dst_en &&
                    ((in1_src_a_en && (in1_src_a == in0_dst)) ||
                     (in1_src_b_en && (in1_src_b == in0_dst)));
  assign pair_waw = in0_dst_en && in1_dst_en && (in1_dst == in0_dst) &&
                    (s_load[1] < s_load[0]);
  assign mul_clash = in0_mul && in1_mul;

  always_comb begin
    if (flush) hz0 = HZ_FLUSH;
    else       hz0 = s_hz[0];
  end

  always_comb begin
    if (flush)               hz1 = HZ_FLUSH;
    else if (!iss[0])        hz1 = HZ_ORDER;
    else if (s_hz[1] != HZ_NONE) hz1 = s_hz[1];
    else if (pair_raw)       hz1 = HZ_PAIR_RAW;
    else if (pair_waw)       hz1 = HZ_PAIR_WAW;
    else if (mul_clash)      hz1 = HZ_RESOURCE;
    else                     hz1 = HZ_NONE;
  end

  assign iss[0] = in0_valid && (hz0 == HZ_NONE);
  assign iss[1] = in1_valid && (hz1 == HZ_NONE);

  dis_scoreboard #(.NREG(NREG), .LATW(LATW)) sb_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .flush   (flush),
    .wr_en   (wr_en),
    .wr_idx  (s_dst),
    .wr_load (s_load),
    .cnt     (cnt)
  );

  assign in0_ready   = iss[0];
  assign in1_ready   = iss[1];
  assign pipe0_valid = iss[0];
  assign pipe1_valid = iss[1];
  assign stall       = (in0_valid && !iss[0]) || (in1_valid && !iss[1]);
endmodule

// File: rtl/dis_issue_unit_chk.sv
module dis_issue_unit_chk #(
  parameter int NREG = 16,
  parameter int LATW = 4,
  localparam int REGW = $clog2(NREG)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            flush,
  input logic            in0_valid,
  input logic            in0_ready,
  input logic [REGW-1:0] in0_src_a,
  input logic            in0_src_a_en,
  input logic [REGW-1:0] in0_dst,
  input logic            in0_dst_en,
  input logic            in0_mul,
  input logic [REGW-1:0] in1_src_a,
  input logic            in1_src_a_en,
  input logic [REGW-1:0] in1_src_b,
  input logic            in1_src_b_en,
  input logic            in1_mul,
  input logic            pipe0_valid,
  input logic            pipe1_valid,
  input logic [LATW-1:0] cnt [NREG]
);
  logic all_clear;
  always_comb begin
    all_clear = 1'b1;
    for (int r = 0; r < NREG; r++) if (cnt[r] != '0) all_clear = 1'b0;
  end

  AST_PAIR_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    pipe1_valid |-> pipe0_valid); // R2
  AST_PIPE0_HANDSHAKE: assert property (@(posedge clk) disable iff (!rst_n)
    pipe0_valid |-> (in0_valid && in0_ready)); // R1
  AST_MUL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (pipe0_valid && pipe1_valid) |-> !(in0_mul && in1_mul)); // R5
  AST_PAIR_RAW_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (pipe1_valid && in0_dst_en) |->
      !((in1_src_a_en && in1_src_a == in0_dst) || (in1_src_b_en && in1_src_b == in0_dst))); // R4
  AST_SRC_AVAILABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (pipe0_valid && in0_src_a_en) |-> (cnt[in0_src_a] == '0)); // R3
  AST_FLUSH_NO_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> (!pipe0_valid && !pipe1_valid)); // R8
  AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> all_clear); // R8
endmodule

bind dis_issue_unit dis_issue_unit_chk #(.NREG(NREG), .LATW(LATW)) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .flush        (flush),
  .in0_valid    (in0_valid),
  .in0_ready    (in0_ready),
  .in0_src_a    (in0_src_a),
  .in0_src_a_en (in0_src_a_en),
  .in0_dst      (in0_dst),
  .in0_dst_en   (in0_dst_en),
  .in0_mul      (in0_mul),
  .in1_src_a    (in1_src_a),
  .in1_src_a_en (in1_src_a_en),
  .in1_src_b    (in1_src_b),
  .in1_src_b_en (in1_src_b_en),
  .in1_mul      (in1_mul),
  .pipe0_valid  (pipe0_valid),
  .pipe1_valid  (pipe1_valid),
  .cnt          (cnt)
);

// File: tb/dis_issue_unit_tb.sv
module dis_issue_unit_tb_top;
  localparam int CLK_P = 10;
  localparam int NREG  = 16;
  localparam int LATW  = 4;
  localparam int REGW  = $clog2(NREG);

  typedef struct {
    bit v; int sa; bit sae; int sb; bit sbe; int d; bit de; int lat; bit mul;
  } ins_t;

  logic clk = 1'b0, rst_n = 1'b0, flush = 1'b0;
  logic in0_valid, in0_ready, in0_src_a_en, in0_src_b_en, in0_dst_en, in0_mul;
  logic in1_valid, in1_ready, in1_src_a_en, in1_src_b_en, in1_dst_en, in1_mul;
  logic [REGW-1:0] in0_src_a, in0_src_b, in0_dst, in1_src_a, in1_src_b, in1_dst;
  logic [LATW-1:0] in0_lat, in1_lat;
  logic pipe0_valid, pipe1_valid, stall;

  int tests = 0, fails = 0;
  bit done = 1'b0;
  int mc [NREG];

  always #(CLK_P/2) clk = ~clk;

  dis_issue_unit #(.NREG(NREG), .LATW(LATW)) dut_i (.*);

  function automatic int ld(int lat);
    return (lat == 0) ? 0 : lat - 1;
  endfunction

  function automatic ins_t mk(bit v, int sa, bit sae, int sb, bit sbe, int d, bit de, int lat, bit mul);
    ins_t i;
    i.v = v; i.sa = sa; i.sae = sae; i.sb = sb; i.sbe = sbe; i.d = d; i.de = de; i.lat = lat; i.mul = mul;
    return i;
  endfunction

  function automatic bit blocked(ins_t i);
    return (i.sae && mc[i.sa] != 0) || (i.sbe && mc[i.sb] != 0) || (i.de && mc[i.d] > ld(i.lat));
  endfunction

  task automatic chk(string tag, string what, logic act, bit exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%b expected=%b", tag, what, act, exp);
    end
  endtask

  task automatic step(ins_t a, ins_t b, bit fl, string tag);
    bit e0, e1, es;
    @(negedge clk);
    flush = fl;
    in0_valid = a.v; in0_src_a = REGW'(a.sa); in0_src_a_en = a.sae; in0_src_b = REGW'(a.sb);
    in0_src_b_en = a.sbe; in0_dst = REGW'(a.d); in0_dst_en = a.de; in0_lat = LATW'(a.lat); in0_mul = a.mul;
    in1_valid = b.v; in1_src_a = REGW'(b.sa); in1_src_a_en = b.sae; in1_src_b = REGW'(b.sb);
    in1_src_b_en = b.sbe; in1_dst = REGW'(b.d); in1_dst_en = b.de; in1_lat = LATW'(b.lat); in1_mul = b.mul;
    e0 = a.v && !fl && !blocked(a);
    e1 = b.v && e0 && !blocked(b)
         && !(a.de && ((b.sae && b.sa == a.d) || (b.sbe && b.sb == a.d)))
         && !(a.de && b.de && a.d == b.d && ld(b.lat) < ld(a.lat))
         && !(a.mul && b.mul);
    es = (a.v && !e0) || (b.v && !e1);
    #1;
    chk(tag, "in0_ready", in0_ready, e0);
    chk(tag, "pipe0_valid", pipe0_valid, e0);
    chk(tag, "in1_ready", in1_ready, e1);
    chk(tag, "pipe1_valid", pipe1_valid, e1);
    chk(tag, "stall", stall, es);
    @(posedge clk);
    for (int r = 0; r < NREG; r++) begin
      int n;
      n = (mc[r] > 0) ? mc[r] - 1 : 0;
      if (e0 && a.de && a.d == r && ld(a.lat) > n) n = ld(a.lat);
      if (e1 && b.de && b.d == r && ld(b.lat) > n) n = ld(b.lat);
      mc[r] = fl ? 0 : n;
    end
  endtask

  ins_t nop;

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    nop = mk(0, 0, 0, 0, 0, 0, 0, 1, 0);
    for (int r = 0; r < NREG; r++) mc[r] = 0;
    in0_valid = 0; in1_valid = 0; in0_src_a = 0; in0_src_a_en = 0; in0_src_b = 0; in0_src_b_en = 0;
    in0_dst = 0; in0_dst_en = 0; in0_lat = 0; in0_mul = 0; in1_src_a = 0; in1_src_a_en = 0;
    in1_src_b = 0; in1_src_b_en = 0; in1_dst = 0; in1_dst_en = 0; in1_lat = 0; in1_mul = 0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // R9: idle after reset, then readers of any register issue at once
    step(nop, nop, 0, "R9 idle");
    step(mk(1, 3, 1, 15, 1, 1, 1, 2, 0), mk(1, 9, 1, 12, 1, 2, 1, 1, 0), 0, "R9");
    // R3: writer latency 3 then a reader each cycle; issues at t+3
    step(mk(1, 0, 0, 0, 0, 5, 1, 3, 0), nop, 0, "R3 writer");
    step(mk(1, 5, 1, 0, 0, 0, 0, 1, 0), nop, 0, "R3 t+1");
    step(mk(1, 0, 0, 5, 1, 0, 0, 1, 0), nop, 0, "R3 t+2");
    step(mk(1, 5, 1, 0, 0, 0, 0, 1, 0), nop, 0, "R3 t+3");
    // R3 latency 0 counts as 1: back-to-back
    step(mk(1, 0, 0, 0, 0, 6, 1, 0, 0), nop, 0, "R3 lat0");
    step(mk(1, 6, 1, 0, 0, 0, 0, 1, 0), nop, 0, "R3 lat0 reader");
    // R10: disabled fields naming a pending register are ignored
    step(mk(1, 0, 0, 0, 0, 7, 1, 9, 0), nop, 0, "R10 writer");
    step(mk(1, 7, 0, 7, 0, 7, 0, 1, 0), mk(1, 7, 0, 8, 1, 7, 0, 1, 0), 0, "R10");
    // R2: slot 0 blocked, slot 1 independent -> neither issues
    step(mk(1, 7, 1, 0, 0, 0, 0, 1, 0), mk(1, 1, 1, 0, 0, 2, 1, 1, 0), 0, "R2 R7");
    // R4: slot 1 reads slot 0 destination
    step(mk(1, 0, 0, 0, 0, 10, 1, 1, 0), mk(1, 10, 1, 0, 0, 11, 1, 1, 0), 0, "R4 pair");
    step(mk(1, 10, 1, 0, 0, 11, 1, 1, 0), nop, 0, "R4 later");
    // R5: both multiplier users
    step(mk(1, 1, 1, 0, 0, 12, 1, 4, 1), mk(1, 2, 1, 0, 0, 13, 1, 4, 1), 0, "R5");
    // R6: pending longer writer blocks shorter writer of same register
    step(mk(1, 0, 0, 0, 0, 4, 1, 8, 0), nop, 0, "R6 long");
    step(mk(1, 0, 0, 0, 0, 4, 1, 2, 0), nop, 0, "R6 short");
    step(mk(1, 0, 0, 0, 0, 14, 1, 5, 0), mk(1, 0, 0, 0, 0, 14, 1, 2, 0), 0, "R6 pair");
    // R8: flush blocks issue and clears all pending counts
    step(mk(1, 0, 0, 0, 0, 9, 1, 12, 0), nop, 0, "R8 writer");
    step(mk(1, 1, 1, 0, 0, 3, 1, 1, 0), mk(1, 2, 1, 0, 0, 8, 1, 1, 0), 1, "R8 flush");
    step(mk(1, 9, 1, 4, 1, 9, 1, 1, 0), mk(1, 14, 1, 12, 1, 4, 1, 1, 0), 0, "R8 after");
    // random traffic over a small register set
    for (int n = 0; n < 4000; n++) begin
      ins_t a, b;
      a = mk(($urandom % 8) != 0, $urandom % 6, $urandom % 2, $urandom % 6, $urandom % 2,
             $urandom % 6, $urandom % 2, $urandom % 8, ($urandom % 4) == 0);
      b = mk(a.v && (($urandom % 4) != 0), $urandom % 6, $urandom % 2, $urandom % 6, $urandom % 2,
             $urandom % 6, $urandom % 2, $urandom % 8, ($urandom % 4) == 0);
      step(a, b, ($urandom % 50) == 0, "R1 R3 R4 R5 R6 R7 random");
    end
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
  end
endmodule